// File: doc/BRIEF.md
# Framed Control-Slot Register Controller

This block sits on a framed, bit-serial backplane bus where every frame holds a fixed number of eight-bit channel slots. Each frame, the block takes one command byte from a control slot and one payload byte from a data slot. The data slot lies half a frame, less one slot, after the control slot. The block answers in the same two slots on its serial output. Both bytes travel least significant bit first. A mode input exchanges the positions of the two slots.

The two low bits of each command byte choose its destination. Code 00 loads the byte into a control register, and code 01 loads it into a diagnostics register. Codes 10 and 11 are discarded. The upper control bits drive the enables of the line side: rate, bearer-slot routing of payload bits, scrambler, line housekeeping bit, and a convergence speedup flag. When the upper four control bits are all ones, the block instead reports a default mode whose flavour follows the rate bit. Clearing the keep bit of the control byte schedules a diagnostics clear for the next frame pulse. A speedup request starts a per-frame countdown, and its length depends on the rate. Payload bits toward and from the line are masked to one bit, two bits or a whole byte, as the rate and routing settings require.

Top module: `cslot_ctrl`

## Requirements
- R1: While reset is asserted and after its release before any frame, all control outputs, `line_tx_o`, `speedup_o` and `ser_o` are 0, and `line_mask_o` is 8'h01.
- R2: A command byte is assembled from `ser_i` LSB first over the control slot. With code 00 in bits [1:0] it becomes the control register. Bit 3 drives `rate_hi_o`. Bits 4, 5 and 7 drive `bearer_route_o`, `scram_en_o` and `hk_o` while not in default mode. Outputs update on the last bit of the slot.
- R3: A command byte with code 01 in bits [1:0] is stored whole as the diagnostics register. The outgoing control slot carries the current diagnostics value on `ser_o` LSB first, and a value written in a slot appears from the next frame onward.
- R4: Command bytes with code 10 or 11 change neither register, and every output stays as it was.
- R5: A control write with bit 2 = 0 clears the diagnostics register at the next frame pulse, so that frame's control slot sends 8'h00. Bit 2 = 1 leaves it unchanged.
- R6: When control bits [7:4] are all 1, `dflt_mode_o` = 1 and `dflt_sel_o` equals bit 3. `bearer_route_o`, `scram_en_o`, `hk_o` and `speedup_o` are 0.
- R7: The data slot is slot C_SLOT + N_CH/2 - 1 and the control slot is C_SLOT. With `slot_swap_i` = 1 the two positions are exchanged, and the block behaves the same otherwise.
- R8: `line_mask_o` is 8'hFF when bearer routing is active, 8'h03 at the high rate and 8'h01 at the low rate. At the end of the data slot, `line_tx_o` takes the received data byte ANDed with the mask in force then.
- R9: At each frame pulse `line_rx_i` ANDed with the current mask is sampled. It is sent LSB first in that frame's outgoing data slot. `ser_o` is 0 outside the two active slots.
- R10: A control write that makes the speedup bit (bit 6) effective when it was not effective before loads a count of SPD_FAST frames (bit 3 = 1) or SPD_SLOW frames (bit 3 = 0). `speedup_o` stays high until that many frame pulses have passed. A write that leaves the speedup bit effective does not reload the count, and a write that makes it ineffective drops `speedup_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock of the serial bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_pulse_i | input | 1 | High during bit 0 of each frame |
| slot_swap_i | input | 1 | Exchanges control and data slot positions |
| ser_i | input | 1 | Serial bus input |
| ser_o | output | 1 | Serial bus output |
| line_rx_i | input | 8 | Payload bits received from the line |
| line_tx_o | output | 8 | Masked payload bits toward the line |
| line_mask_o | output | 8 | Active payload bit mask |
| rate_hi_o | output | 1 | High line rate selected |
| bearer_route_o | output | 1 | Payload carried in the first bearer slot |
| scram_en_o | output | 1 | Scrambler enable |
| hk_o | output | 1 | Housekeeping bit for the line |
| speedup_o | output | 1 | Convergence speedup flag |
| dflt_mode_o | output | 1 | Default mode active |
| dflt_sel_o | output | 1 | Which default mode |

## Verification
The bench builds the block with N_CH = 4, SPD_FAST = 3 and SPD_SLOW = 5. A frame is then 32 bit clocks, the data slot sits directly after the control slot, and the speedup windows close within a handful of frames. With these values, every one of the 256 command byte values can be sent in both slot orders. Each frame is checked against an arithmetic model of the registers, the pending clear, the masks and the countdown, which covers the default-mode patterns, the reserved codes, and the mask taken before and after a same-frame control write.

// File: rtl/cslot_pkg.sv
package cslot_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'b00,
    SEL_DIAG  = 2'b01,
    SEL_RSV_A = 2'b10,
    SEL_RSV_B = 2'b11
  } sel_e;

  typedef struct packed {
    logic       hk;
    logic       speedup;
    logic       scram;
    logic       bearer;
    logic       rate;
    logic       diag_keep;
    logic [1:0] sel;
  } ctrl_t;

  function automatic logic is_dflt(ctrl_t c);
    return c.hk & c.speedup & c.scram & c.bearer;
  endfunction

  function automatic logic [BYTE_W-1:0] mask_of(ctrl_t c);
    if (c.bearer && !is_dflt(c)) return 8'hFF;
    if (c.rate) return 8'h03;
    return 8'h01;
  endfunction
endpackage

// File: rtl/cslot_timing.sv
module cslot_timing #(
  parameter int unsigned N_CH   = 32,
  parameter int unsigned C_SLOT = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_pulse_i,
  input  logic       slot_swap_i,
  output logic [2:0] bit_o,
  output logic       c_act_o,
  output logic       d_act_o,
  output logic       c_last_o,
  output logic       d_last_o
);
  localparam int unsigned FRAME_BITS = N_CH * 8;
  localparam int unsigned POS_W      = $clog2(FRAME_BITS);
  localparam int unsigned SLOT_W     = POS_W - 3;
  localparam int unsigned D_SLOT     = C_SLOT + N_CH / 2 - 1;

  logic [POS_W-1:0]  pos_q, pos_d, idx;
  logic [SLOT_W-1:0] slot, c_num, d_num;

  always_comb begin
    idx   = frame_pulse_i ? '0 : pos_q;
    pos_d = (idx == POS_W'(FRAME_BITS - 1)) ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  always_comb begin
    slot     = idx[POS_W-1:3];
    bit_o    = idx[2:0];
    c_num    = slot_swap_i ? SLOT_W'(D_SLOT) : SLOT_W'(C_SLOT);
    d_num    = slot_swap_i ? SLOT_W'(C_SLOT) : SLOT_W'(D_SLOT);
    c_act_o  = (slot == c_num);
    d_act_o  = (slot == d_num);
    c_last_o = c_act_o && (bit_o == 3'd7);
    d_last_o = d_act_o && (bit_o == 3'd7);
  end

  AST_SLOT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c_act_o && d_act_o)); // R7
  AST_FP_NOT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_i |-> !c_last_o && !d_last_o); // R7
endmodule

// File: rtl/cslot_regs.sv
module cslot_regs
  import cslot_pkg::*;
#(
  parameter int unsigned SPD_FAST = 240,
  parameter int unsigned SPD_SLOW = 480
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_pulse_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output ctrl_t             ctrl_o,
  output logic [BYTE_W-1:0] diag_o,
  output logic              clr_now_o,
  output logic              speedup_o
);
  localparam int unsigned SPD_MAX = (SPD_FAST > SPD_SLOW) ? SPD_FAST : SPD_SLOW;
  localparam int unsigned CNT_W   = $clog2(SPD_MAX + 1);

  ctrl_t             ctrl_q, ctrl_d, new_c;
  logic [BYTE_W-1:0] diag_q, diag_d;
  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  sel_e              wr_sel;
  logic              wr_ctrl, wr_diag, new_eff, old_eff;

  always_comb begin
    wr_sel  = sel_e'(wr_byte_i[1:0]);
    wr_ctrl = wr_i && (wr_sel == SEL_CTRL);
    wr_diag = wr_i && (wr_sel == SEL_DIAG);
    new_c   = ctrl_t'(wr_byte_i);
    new_eff = new_c.speedup && !is_dflt(new_c);
    old_eff = ctrl_q.speedup && !is_dflt(ctrl_q);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    diag_d = diag_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (frame_pulse_i) begin
      if (pend_q) begin
        diag_d = '0;
        pend_d = 1'b0;
      end
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
    if (wr_ctrl) begin
      ctrl_d = new_c;
      if (!new_c.diag_keep) pend_d = 1'b1;
      if (!new_eff)         cnt_d  = '0;
      else if (!old_eff)    cnt_d  = new_c.rate ? CNT_W'(SPD_FAST) : CNT_W'(SPD_SLOW);
    end
    if (wr_diag) diag_d = wr_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      diag_q <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      diag_q <= diag_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign diag_o    = diag_q;
  assign clr_now_o = frame_pulse_i && pend_q;
  assign speedup_o = (cnt_q != '0);

  AST_RSV_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wr_byte_i[1] |=> $stable(ctrl_q)); // R4
  AST_RSV_DIAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wr_byte_i[1] |=> $stable(diag_q)); // R4
  AST_DIAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_i && pend_q |=> diag_q == '0); // R5
  AST_DIAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_pulse_i && !wr_diag |=> $stable(diag_q)); // R5
  AST_DFLT_NO_SPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_dflt(ctrl_q) |-> cnt_q == '0); // R6
  AST_SPD_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_pulse_i && !wr_ctrl |=> $stable(cnt_q)); // R10
  AST_SPD_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1); // R10
endmodule

// File: rtl/cslot_dpath.sv
module cslot_dpath
  import cslot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_pulse_i,
  input  logic              d_last_i,
  input  logic [BYTE_W-1:0] d_byte_i,
  input  ctrl_t             ctrl_i,
  input  logic [BYTE_W-1:0] line_rx_i,
  output logic [BYTE_W-1:0] mask_o,
  output logic [BYTE_W-1:0] line_tx_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  logic [BYTE_W-1:0] tx_q, tx_d, rx_q, rx_d, rx_masked;

  always_comb begin
    mask_o    = mask_of(ctrl_i);
    rx_masked = line_rx_i & mask_o;
    tx_d      = d_last_i ? (d_byte_i & mask_o) : tx_q;
    rx_d      = frame_pulse_i ? rx_masked : rx_q;
    rx_byte_o = frame_pulse_i ? rx_masked : rx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign line_tx_o = tx_q;

  AST_MASK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o == 8'h01 || mask_o == 8'h03 || mask_o == 8'hFF); // R8
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !d_last_i |=> $stable(line_tx_o)); // R8
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_pulse_i |=> $stable(rx_q)); // R9
endmodule

// File: rtl/cslot_ctrl.sv
module cslot_ctrl
  import cslot_pkg::*;
#(
  parameter int unsigned N_CH     = 32,
  parameter int unsigned C_SLOT   = 0,
  parameter int unsigned SPD_FAST = 240,
  parameter int unsigned SPD_SLOW = 480
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_pulse_i,
  input  logic       slot_swap_i,
  input  logic       ser_i,
  output logic       ser_o,
  input  logic [7:0] line_rx_i,
  output logic [7:0] line_tx_o,
  output logic [7:0] line_mask_o,
  output logic       rate_hi_o,
  output logic       bearer_route_o,
  output logic       scram_en_o,
  output logic       hk_o,
  output logic       speedup_o,
  output logic       dflt_mode_o,
  output logic       dflt_sel_o
);
  logic              rst_s1_q, rst_s2_q, rst_n;
  logic [2:0]        bit_idx;
  logic              c_act, d_act, c_last, d_last;
  logic [BYTE_W-1:0] sh_q, in_byte, diag, rx_byte, c_src;
  logic              clr_now, dflt;
  ctrl_t             ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n = rst_s2_q;

  cslot_timing #(.N_CH(N_CH), .C_SLOT(C_SLOT)) u_timing (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .frame_pulse_i (frame_pulse_i),
    .slot_swap_i   (slot_swap_i),
    .bit_o         (bit_idx),
    .c_act_o       (c_act),
    .d_act_o       (d_act),
    .c_last_o      (c_last),
    .d_last_o      (d_last)
  );

  assign in_byte = {ser_i, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= in_byte;
  end

  cslot_regs #(.SPD_FAST(SPD_FAST), .SPD_SLOW(SPD_SLOW)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .frame_pulse_i (frame_pulse_i),
    .wr_i          (c_last),
    .wr_byte_i     (in_byte),
    .ctrl_o        (ctrl),
    .diag_o        (diag),
    .clr_now_o     (clr_now),
    .speedup_o     (speedup_o)
  );

  cslot_dpath u_dpath (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .frame_pulse_i (frame_pulse_i),
    .d_last_i      (d_last),
    .d_byte_i      (in_byte),
    .ctrl_i        (ctrl),
    .line_rx_i     (line_rx_i),
    .mask_o        (line_mask_o),
    .line_tx_o     (line_tx_o),
    .rx_byte_o     (rx_byte)
  );

  always_comb begin
    dflt           = is_dflt(ctrl);
    rate_hi_o      = ctrl.rate;
    bearer_route_o = ctrl.bearer && !dflt;
    scram_en_o     = ctrl.scram && !dflt;
    hk_o           = ctrl.hk && !dflt;
    dflt_mode_o    = dflt;
    dflt_sel_o     = dflt && ctrl.rate;
    c_src          = clr_now ? '0 : diag;
    if (c_act)      ser_o = c_src[bit_idx];
    else if (d_act) ser_o = rx_byte[bit_idx];
    else            ser_o = 1'b0;
  end

  AST_IDLE_SLOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    !c_act && !d_act |-> !ser_o); // R9
  AST_DFLT_OUTS: assert property (@(posedge clk_i) disable iff (!rst_n)
    dflt_mode_o |-> !bearer_route_o && !scram_en_o && !hk_o && !speedup_o); // R6
endmodule

// File: tb/cslot_ctrl_tb.sv
module cslot_ctrl_tb;
  localparam int unsigned N_CH     = 4;
  localparam int unsigned SPD_FAST = 3;
  localparam int unsigned SPD_SLOW = 5;
  localparam int unsigned FBITS    = N_CH * 8;
  localparam int unsigned CS       = 0;
  localparam int unsigned DS       = CS + N_CH / 2 - 1;

  logic       clk, rst_n, fp, swap, ser_i, ser_o;
  logic [7:0] line_rx, line_tx, line_mask;
  logic       rate_hi, bearer, scram, hk, spd, dflt, dsel;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_ctrl, m_diag;
  logic       m_pend;
  int         m_cnt;
  logic [7:0] m_tx;

  cslot_ctrl #(.N_CH(N_CH), .C_SLOT(CS), .SPD_FAST(SPD_FAST), .SPD_SLOW(SPD_SLOW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_pulse_i(fp), .slot_swap_i(swap),
    .ser_i(ser_i), .ser_o(ser_o), .line_rx_i(line_rx), .line_tx_o(line_tx),
    .line_mask_o(line_mask), .rate_hi_o(rate_hi), .bearer_route_o(bearer),
    .scram_en_o(scram), .hk_o(hk), .speedup_o(spd), .dflt_mode_o(dflt),
    .dflt_sel_o(dsel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic m_dflt(input logic [7:0] c);
    return &c[7:4];
  endfunction

  function automatic logic [7:0] m_mask(input logic [7:0] c);
    if (c[4] && !m_dflt(c)) return 8'hFF;
    return c[3] ? 8'h03 : 8'h01;
  endfunction

  task automatic model_cwrite(input logic [7:0] c);
    logic ne, oe;
    if (c[1:0] == 2'b00) begin
      ne = c[6] && !m_dflt(c);
      oe = m_ctrl[6] && !m_dflt(m_ctrl);
      if (!ne)      m_cnt = 0;
      else if (!oe) m_cnt = c[3] ? SPD_FAST : SPD_SLOW;
      m_ctrl = c;
      if (!c[2]) m_pend = 1'b1;
    end else if (c[1:0] == 2'b01) begin
      m_diag = c;
    end
  endtask

  // One frame: command byte c, data byte d, line receive value rx.
  task automatic run_frame(input logic [7:0] c, input logic [7:0] d, input logic [7:0] rx);
    logic [7:0] exp_c, exp_d, got_c, got_d, quiet;
    logic       was_pend;
    int         cslot, dslot;
    cslot = swap ? DS : CS;
    dslot = swap ? CS : DS;
    // model: frame pulse effects
    was_pend = m_pend;
    if (m_pend) begin m_diag = 8'h00; m_pend = 1'b0; end
    if (m_cnt > 0) m_cnt--;
    exp_d = rx & m_mask(m_ctrl);
    exp_c = m_diag;
    if (swap) begin
      m_tx = d & m_mask(m_ctrl);
      model_cwrite(c);
    end else begin
      model_cwrite(c);
      m_tx = d & m_mask(m_ctrl);
    end
    got_c = '0; got_d = '0; quiet = '0;
    for (int b = 0; b < int'(FBITS); b++) begin
      @(negedge clk);
      fp = (b == 0);
      if (b == 0) line_rx = rx;
      if (b / 8 == cslot)      ser_i = c[b % 8];
      else if (b / 8 == dslot) ser_i = d[b % 8];
      else                     ser_i = 1'b0;
      #1;
      if (b / 8 == cslot)      got_c[b % 8] = ser_o;
      else if (b / 8 == dslot) got_d[b % 8] = ser_o;
      else                     quiet[0] = quiet[0] | ser_o;
    end
    @(posedge clk);
    #1;
    check(was_pend ? "R5" : "R3", got_c, exp_c);
    check("R9", got_d, exp_d);
    check("R9", quiet, 8'h00);
    check(c[1] ? "R4" : "R2", {rate_hi, bearer, scram, hk},
          {m_ctrl[3], m_ctrl[4] && !m_dflt(m_ctrl), m_ctrl[5] && !m_dflt(m_ctrl),
           m_ctrl[7] && !m_dflt(m_ctrl)});
    check("R6", {dflt, dsel}, {m_dflt(m_ctrl), m_dflt(m_ctrl) && m_ctrl[3]});
    check("R8", line_mask, m_mask(m_ctrl));
    check(swap ? "R7" : "R8", line_tx, m_tx);
    check("R10", {7'd0, spd}, {7'd0, m_cnt > 0});
  endtask

  initial begin
    rst_n = 1'b0; fp = 1'b0; swap = 1'b0; ser_i = 1'b0; line_rx = 8'h00;
    m_ctrl = 8'h00; m_diag = 8'h00; m_pend = 1'b0; m_cnt = 0; m_tx = 8'h00;
    repeat (4) @(negedge clk);
    #1;
    check("R1", {rate_hi, bearer, scram, hk, spd, dflt, dsel, ser_o}, 8'h00);
    check("R1", line_mask, 8'h01);
    check("R1", line_tx, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1", {rate_hi, bearer, scram, hk, spd, dflt, dsel, ser_o}, 8'h00);
    check("R1", line_mask, 8'h01);
    // full sweep of command bytes, both slot orders (R7 with swap)
    for (int s = 0; s < 2; s++) begin
      swap = s[0];
      for (int v = 0; v < 256; v++) begin
        logic [7:0] vb;
        vb = v[7:0];
        run_frame(vb, vb ^ 8'h5A, {vb[3:0], vb[7:4]});
      end
    end
    swap = 1'b0;
    // speedup windows, reserved codes in between (R10, R4)
    run_frame(8'h0C, 8'hFF, 8'hFF);
    run_frame(8'h4C, 8'hFF, 8'hFF);
    for (int k = 0; k < 5; k++) run_frame(8'h03, 8'h33, 8'hC3);
    run_frame(8'h04, 8'h01, 8'h01);
    run_frame(8'h44, 8'h01, 8'h01);
    run_frame(8'h44, 8'h01, 8'h01);
    for (int k = 0; k < 7; k++) run_frame(8'h02, 8'h0F, 8'hF0);
    run_frame(8'h4C, 8'h00, 8'h00);
    run_frame(8'h0D, 8'hAA, 8'h55);
    run_frame(8'h0C, 8'h00, 8'h00);
    // diagnostics write then kept, then cleared (R3, R5)
    run_frame(8'hA5 | 8'h01, 8'h00, 8'h00);
    run_frame(8'h03, 8'h00, 8'h00);
    run_frame(8'h04, 8'h00, 8'h00);
    run_frame(8'h03, 8'h00, 8'h00);
    run_frame(8'h00, 8'h00, 8'h00);
    run_frame(8'h03, 8'h00, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule